// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter with Clear-to-Send Gating

This block turns parallel words into asynchronous serial frames on a single output line. A frame has a low start bit, then eight or nine data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. A one-entry holding buffer accepts a new word while the shift register is still sending the previous one, so frames can follow each other without a gap. The bit period is 16 × (n + 1) clock cycles, where n is the divider input.

When flow control is enabled, the clear-to-send input is checked wherever a frame could begin: at the end of the last stop bit, and in idle when a word arrives. If the input is high, the transfer clock is frozen and the line stays high until the input drops. The start bit then follows on the next cycle. Two flags report an empty buffer and an idle shifter. A single sticky interrupt request follows one of these two events, chosen by a select input, and stays set until it is acknowledged.

The controller has six states. IDLE means nothing is loaded. READY means a word is loaded and waits for clear-to-send or enable. START, DATA and PARITY send their bits, and STOP sends one or two stop bits. The transitions are:
- IDLE→START or IDLE→READY when a buffered word is taken.
- READY→START when sending is allowed.
- START→DATA at the end of the bit.
- DATA→PARITY or DATA→STOP after the last data bit.
- PARITY→STOP at the end of the parity bit.
- STOP→START, STOP→READY or STOP→IDLE after the final stop bit, depending on whether a word is pending and sending is allowed.

Configuration inputs are expected to stay stable while a frame is in flight.

Top module: `uart_tx_cts`

## Requirements
- R1: Every bit on `txd` lasts exactly 16 × (`div_n` + 1) clock cycles.
- R2: A frame is one low start bit, then the data bits LSB first (9 when `len9`=1, else the 8 low bits of `wr_data`), then a parity bit only when `par_en`=1, then stop bits driven high (two when `two_stop`=1, else one).
- R3: With `par_odd`=0 the parity bit makes the number of ones across the sent data bits and the parity bit even; with `par_odd`=1 it makes that count odd. Bit 8 is counted only in 9-bit mode.
- R4: A write is accepted when `buf_empty`=1, and `buf_empty` reads 0 from the cycle after the write. `buf_empty` returns to 1 in the cycle the word moves to the shift register. That move happens right away when the shifter is idle, or at the end of the last stop bit of the current frame.
- R5: A write while `buf_empty`=0 is ignored; the buffered word is unchanged and no extra frame is sent.
- R6: `shift_idle` is 0 from the moment a word is loaded into the shift register until the last stop bit ends with no word pending, and 1 otherwise.
- R7: With `flow_en`=1, a frame starts only in a cycle where `cts`=0. While `cts`=1, a loaded word holds the line high. The start bit appears in the cycle after `cts` falls.
- R8: With `flow_en`=0, `cts` has no effect, and a buffered word starts right after the previous frame's last stop bit with no idle cycles.
- R9: `irq` is set when a word moves to the shifter if `irq_sel`=0, and when a frame completes with nothing pending if `irq_sel`=1. It stays set until `irq_ack` is sampled high; a new event in the same cycle wins over the acknowledge.
- R10: With `tx_en`=0 no word is loaded and no frame starts; a frame already in progress finishes.
- R11: `txd` is high whenever no frame is being sent, including after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the bit-rate count source |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| div_n | input | 8 | Divider value n |
| len9 | input | 1 | 1 selects nine data bits |
| par_en | input | 1 | 1 inserts a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | 1 sends two stop bits |
| flow_en | input | 1 | 1 enables clear-to-send gating |
| cts | input | 1 | Clear-to-send, low means send allowed |
| irq_sel | input | 1 | Interrupt source: 0 buffer empty, 1 transmit complete |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Word to send |
| irq_ack | input | 1 | Clears the pending interrupt |
| txd | output | 1 | Serial data line |
| buf_empty | output | 1 | Holding buffer is empty |
| shift_idle | output | 1 | Shift register holds no frame |
| irq | output | 1 | Pending interrupt request |

## Verification
Random words are sent under random mixes of length, parity mode, parity polarity, stop count, divider and interrupt source, and each decoded frame is compared with one built by a bench function. These runs tell apart errors in bit order, parity polarity, parity coverage of bit 8 and stop count. Directed cases cover the rest. A single start bit is timed to pin the divider formula. Two back-to-back frames check the gap and buffer hand-over, while a third write to the full buffer checks that it is dropped. Clear-to-send is held high both from idle and across a stop bit, to show the hold and the one-cycle restart. Transmit enable is removed before a write and in mid-frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READY,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;
endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_n,
    output logic             bit_end
);
    localparam int CNT_W = DIV_W + $clog2(OVS) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    // last count of a bit: (n + 1) * OVS - 1
    assign last    = (CNT_W'(div_n) + CNT_W'(1)) * CNT_W'(OVS) - CNT_W'(1);
    assign bit_end = run && (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || bit_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(div_n)) |-> (cnt_q <= last)) else $error("bit counter overran"); // R1
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
    import uart_tx_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int OVS    = 16,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [DIV_W-1:0]  div_n,
    input  logic              len9,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              flow_en,
    input  logic              cts,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    output logic              take,
    output logic              done,
    output logic              txd,
    output logic              idle
);
    localparam int IDX_W = $clog2(DATA_W + 1);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_idx;
    logic              par_q;
    logic              stop2_q;
    logic              bit_end;
    logic              run;
    logic              can_go;
    logic [DATA_W-1:0] masked;
    logic              par_calc;

    assign run      = (state_q == ST_START) || (state_q == ST_DATA) ||
                      (state_q == ST_PARITY) || (state_q == ST_STOP);
    assign can_go   = tx_en && (!flow_en || !cts);
    assign last_idx = len9 ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
    assign masked   = len9 ? buf_data : {1'b0, buf_data[DATA_W-2:0]};
    assign par_calc = (^masked) ^ par_odd;

    uart_tx_bit_timer #(.DIV_W(DIV_W), .OVS(OVS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div_n   (div_n),
        .bit_end (bit_end)
    );

    // next state, load and completion strobes
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_en && buf_full) begin
                    take    = 1'b1;
                    state_d = can_go ? ST_START : ST_READY;
                end
            end
            ST_READY: begin
                if (can_go) state_d = ST_START;
            end
            ST_START: begin
                if (bit_end) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end && idx_q == last_idx) state_d = par_en ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: begin
                if (bit_end) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (bit_end && (!two_stop || stop2_q)) begin
                    if (tx_en && buf_full) begin
                        take    = 1'b1;
                        state_d = can_go ? ST_START : ST_READY;
                    end else begin
                        done    = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            idx_q   <= '0;
            par_q   <= 1'b0;
            stop2_q <= 1'b0;
        end else if (take) begin
            shreg_q <= buf_data;
            idx_q   <= '0;
            par_q   <= par_calc;
            stop2_q <= 1'b0;
        end else if (bit_end) begin
            if (state_q == ST_DATA) begin
                shreg_q <= shreg_q >> 1;
                idx_q   <= idx_q + IDX_W'(1);
            end
            if (state_q == ST_STOP) stop2_q <= two_stop && !stop2_q;
        end
    end

    // line and status outputs
    always_comb begin
        unique case (state_q)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg_q[0];
            ST_PARITY: txd = par_q;
            default:   txd = 1'b1;
        endcase
        idle = (state_q == ST_IDLE);
    end

    AST_START_NEEDS_CTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && $past(state_q) != ST_START && $past(flow_en)) |-> !$past(cts))
        else $error("frame began while cts high"); // R7
    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !tx_en) |=> (state_q == ST_IDLE))
        else $error("left idle while disabled"); // R10
    AST_LINE_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_READY) |-> txd)
        else $error("line low outside a frame"); // R11
endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts #(
    parameter int DIV_W  = 8,
    parameter int OVS    = 16,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [DIV_W-1:0]  div_n,
    input  logic              len9,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              flow_en,
    input  logic              cts,
    input  logic              irq_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_ack,
    output logic              txd,
    output logic              buf_empty,
    output logic              shift_idle,
    output logic              irq
);
    logic              buf_full_q;
    logic [DATA_W-1:0] buf_data_q;
    logic              irq_q;
    logic              take;
    logic              done;
    logic              irq_set;

    uart_tx_frame #(.DIV_W(DIV_W), .OVS(OVS), .DATA_W(DATA_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .div_n    (div_n),
        .len9     (len9),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .two_stop (two_stop),
        .flow_en  (flow_en),
        .cts      (cts),
        .buf_full (buf_full_q),
        .buf_data (buf_data_q),
        .take     (take),
        .done     (done),
        .txd      (txd),
        .idle     (shift_idle)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_full_q <= 1'b0;
            buf_data_q <= '0;
        end else if (wr_en && !buf_full_q) begin
            buf_full_q <= 1'b1;
            buf_data_q <= wr_data;
        end else if (take) begin
            buf_full_q <= 1'b0;
        end
    end

    assign irq_set = irq_sel ? done : take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (irq_set) irq_q <= 1'b1;
        else if (irq_ack) irq_q <= 1'b0;
    end

    assign buf_empty = !buf_full_q;
    assign irq       = irq_q;

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full_q && !take) |=> (buf_full_q && $stable(buf_data_q)))
        else $error("buffered word changed while full"); // R5
    AST_TAKE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> buf_full_q) else $error("load from empty buffer"); // R4
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_ack) |=> irq_q) else $error("irq dropped without ack"); // R9
endmodule

// File: tb/tb_uart_tx_cts.sv
module tb_uart_tx_cts;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b1;
    logic [7:0] div_n = 8'd0;
    logic       len9 = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
    logic       flow_en = 1'b0, cts = 1'b0, irq_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       irq_ack = 1'b0;
    logic       txd, buf_empty, shift_idle, irq;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int per = 16;

    uart_tx_cts dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .div_n(div_n), .len9(len9),
        .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop), .flow_en(flow_en),
        .cts(cts), .irq_sel(irq_sel), .wr_en(wr_en), .wr_data(wr_data),
        .irq_ack(irq_ack), .txd(txd), .buf_empty(buf_empty),
        .shift_idle(shift_idle), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_div(input int n);
        div_n = 8'(n);
        per = 16 * (n + 1);
    endtask

    function automatic void exp_frame(input logic [8:0] d, input logic l9, input logic pe,
                                      input logic po, input logic ts,
                                      output logic [12:0] b, output int nb);
        int k;
        logic p;
        k = 0;
        p = po;
        b = '0;
        for (int i = 0; i < (l9 ? 9 : 8); i++) begin
            b[k] = d[i];
            p = p ^ d[i];
            k++;
        end
        if (pe) begin b[k] = p; k++; end
        b[k] = 1'b1; k++;
        if (ts) begin b[k] = 1'b1; k++; end
        nb = k;
    endfunction

    task automatic write_word(input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic recv(input int nb, output logic [12:0] b, output int tf);
        int guard;
        guard = 0;
        b = '0;
        while (txd !== 1'b0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        tf = cyc;
        repeat (per / 2) @(negedge clk);
        chk("R2 start bit low", int'(txd), 0);
        for (int i = 0; i < nb; i++) begin
            repeat (per) @(negedge clk);
            b[i] = txd;
        end
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        while (shift_idle !== 1'b1 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic ack_irq();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic expect_frame(input logic [8:0] d, input string req);
        logic [12:0] e, g;
        int nb, tf;
        exp_frame(d, len9, par_en, par_odd, two_stop, e, nb);
        recv(nb, g, tf);
        chk(req, int'(g), int'(e));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1: watchdog expired, actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [12:0] e, ga, gb;
        int nb, ta, tb2, low;
        bit seen_low;
        void'($urandom(32'd4021));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset txd", int'(txd), 1);
        chk("R4 reset buf_empty", int'(buf_empty), 1);
        chk("R6 reset shift_idle", int'(shift_idle), 1);
        chk("R9 reset irq", int'(irq), 0);

        // R1: start bit width with LSB = 1
        set_div(2);
        write_word(9'h0FF);
        while (txd !== 1'b0) @(negedge clk);
        low = 0;
        while (txd === 1'b0 && low < 1000) begin
            @(negedge clk);
            low++;
        end
        chk("R1 start bit length", low, 48);
        wait_idle();
        ack_irq();

        // R3 directed: bit 8 counted only in 9-bit mode
        set_div(0);
        par_en = 1'b1; par_odd = 1'b0;
        len9 = 1'b1;
        write_word(9'h100);
        expect_frame(9'h100, "R3 nine-bit even parity");
        wait_idle();
        len9 = 1'b0;
        write_word(9'h100);
        expect_frame(9'h100, "R3 eight-bit ignores bit 8");
        wait_idle();
        ack_irq();

        // R2 R3 R6 R9: random configurations
        for (int t = 0; t < 16; t++) begin
            logic [8:0] d;
            set_div(int'($urandom_range(0, 1)));
            len9 = 1'($urandom); par_en = 1'($urandom);
            par_odd = 1'($urandom); two_stop = 1'($urandom);
            irq_sel = 1'($urandom); flow_en = 1'($urandom); cts = 1'b0;
            d = 9'($urandom);
            ack_irq();
            write_word(d);
            expect_frame(d, "R2 R3 random frame");
            chk("R9 irq before completion", int'(irq), irq_sel ? 0 : 1);
            wait_idle();
            chk("R6 idle after frame", int'(shift_idle), 1);
            chk("R9 irq after completion", int'(irq), 1);
            ack_irq();
            chk("R9 irq cleared by ack", int'(irq), 0);
        end

        // R4 R5 R8: back-to-back, third write dropped, cts ignored
        set_div(0);
        len9 = 1'b0; par_en = 1'b0; two_stop = 1'b0; flow_en = 1'b0; cts = 1'b1;
        exp_frame(9'h0A5, 1'b0, 1'b0, 1'b0, 1'b0, e, nb);
        write_word(9'h0A5);
        fork
            recv(nb, ga, ta);
            begin
                repeat (30) @(negedge clk);
                chk("R4 buffer empty once loaded", int'(buf_empty), 1);
                chk("R6 shifter busy", int'(shift_idle), 0);
                write_word(9'h03C);
                chk("R4 buffer full after write", int'(buf_empty), 0);
                write_word(9'h0FF);
            end
        join
        chk("R2 first frame", int'(ga), int'(e));
        recv(nb, gb, tb2);
        exp_frame(9'h03C, 1'b0, 1'b0, 1'b0, 1'b0, e, nb);
        chk("R5 second frame keeps first buffered word", int'(gb), int'(e));
        chk("R8 no gap between frames", tb2 - ta, 160);
        seen_low = 1'b0;
        repeat (400) begin
            @(negedge clk);
            if (txd === 1'b0) seen_low = 1'b1;
        end
        chk("R5 dropped word never sent", int'(seen_low), 0);
        chk("R6 idle after pair", int'(shift_idle), 1);

        // R7: cts high from idle
        flow_en = 1'b1; cts = 1'b1;
        write_word(9'h05A);
        @(negedge clk);
        chk("R4 word moved while held", int'(buf_empty), 1);
        chk("R6 shifter loaded while held", int'(shift_idle), 0);
        seen_low = 1'b0;
        repeat (100) begin
            @(negedge clk);
            if (txd === 1'b0) seen_low = 1'b1;
        end
        chk("R7 line held high while cts high", int'(seen_low), 0);
        cts = 1'b0;
        @(negedge clk);
        chk("R7 start bit one cycle after cts low", int'(txd), 0);
        expect_frame(9'h05A, "R7 held frame data");

        // R7: cts rises during a frame, next frame held at stop bit
        write_word(9'h011);
        fork
            expect_frame(9'h011, "R7 frame before hold");
            begin
                repeat (40) @(negedge clk);
                write_word(9'h0E7);
                cts = 1'b1;
            end
        join
        repeat (per) @(negedge clk);
        chk("R7 line high in hold", int'(txd), 1);
        chk("R6 shifter busy in hold", int'(shift_idle), 0);
        chk("R4 buffer empty in hold", int'(buf_empty), 1);
        cts = 1'b0;
        @(negedge clk);
        chk("R7 restart next cycle", int'(txd), 0);
        expect_frame(9'h0E7, "R7 resumed frame data");
        wait_idle();

        // R10: disabled transmitter
        flow_en = 1'b0;
        tx_en = 1'b0;
        write_word(9'h0C3);
        seen_low = 1'b0;
        repeat (200) begin
            @(negedge clk);
            if (txd === 1'b0) seen_low = 1'b1;
        end
        chk("R10 nothing sent while disabled", int'(seen_low), 0);
        chk("R10 word stays buffered", int'(buf_empty), 0);
        chk("R10 shifter stays idle", int'(shift_idle), 1);
        tx_en = 1'b1;
        expect_frame(9'h0C3, "R10 sent after enable");
        wait_idle();
        write_word(9'h096);
        fork
            expect_frame(9'h096, "R10 frame in flight completes");
            begin
                repeat (20) @(negedge clk);
                tx_en = 1'b0;
            end
        join
        wait_idle();
        chk("R11 line high after frame", int'(txd), 1);
        tx_en = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule